// File: doc/BRIEF.md
# Software Write-Protection Sequence Unit

This unit sits between the bus write strobes and the page-write controller of a byte-wide nonvolatile memory. For every write strobe it decides, in the same cycle, whether the byte may enter the page register (`permit_o`) or whether the strobe was a step of a protection command and must not be stored (`cmd_o`). Two command sequences alternate between two fixed addresses. A three-step arming sequence turns protection on. A six-step disarming sequence turns it off. All codes and addresses are parameters.

The protection state is one flag that stands in for a nonvolatile bit. The `rst_n` input loads the flag with its factory value once. The `pw_cycle_i` input models a supply collapse and recovery: it blocks all writes and clears the sequence tracker, but it leaves the flag as it was. While protection is on, the only way to store data is to send the arming sequence first. That sequence opens a page-load window for a limited number of bytes. The window also closes after a limited number of idle cycles.

Top module: `wp_seq_guard`

## Requirements
- R1: Each strobe of the arming sequence (0xAA to 0x1555, 0x55 to 0x0AAA, 0xA0 to 0x1555) raises `cmd_o` and keeps `permit_o` low, and the third strobe turns protection on.
- R2: While protection is on and no page-load window is open, a write that is not a command step is refused: both `permit_o` and `cmd_o` stay low.
- R3: Completing the arming sequence opens a page-load window. In that window every write is data and is permitted, including bytes equal to a command code.
- R4: The window closes after PAGE_BYTES permitted writes, or after LOAD_GAP consecutive cycles without a strobe. A strobe after LOAD_GAP-1 idle cycles still falls inside the window.
- R5: The six-step disarming sequence (0xAA, 0x55, 0x80, 0xAA, 0x55, 0x20, alternating 0x1555 / 0x0AAA / 0x1555 ...) raises `cmd_o` on every step and turns protection off. Later plain writes are then permitted.
- R6: A strobe that does not match the next expected step returns the tracker to idle. It is not treated as a first step. It is permitted if protection is off and refused if protection is on.
- R7: `permit_o` and `cmd_o` are never high together, so a command byte is never stored, even with protection off.
- R8: While `pw_cycle_i` is high, both outputs stay low. The pulse discards a partial sequence and an open window, and it leaves the protection flag unchanged.
- R9: During and after `rst_n`, both outputs are low while no strobe is present. Reset reloads the flag with FLAG_INIT (default 0, unprotected).
- R10: In a cycle without a write strobe, both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset: tracker to idle, flag to FLAG_INIT |
| pw_cycle_i | input | 1 | Supply-transition indication: blocks writes, clears tracker and window, keeps the flag |
| wr_i | input | 1 | One-cycle write strobe |
| addr_i | input | AW | Write address |
| data_i | input | DW | Write data |
| permit_o | output | 1 | This strobe may be loaded into the page register |
| cmd_o | output | 1 | This strobe was consumed as a command step |

## Verification
The hardest state to reach is a disarming or arming sequence that is interrupted part way, because the tracker then sits in an intermediate step that never shows at the ports. The stimulus enters these steps deliberately. It sends two correct steps followed by a wrong byte, and it raises the supply-transition pulse after the first step. It then probes with the byte that the lost step would have accepted, and checks that the byte is refused as a plain write. The window edges are reached by counting exact idle gaps of LOAD_GAP-1 and LOAD_GAP cycles, and by filling the window to PAGE_BYTES writes and then sending one more.

// File: rtl/wp_seq_pkg.sv
package wp_seq_pkg;
   // tracker position: which command step is expected next
   typedef enum logic [2:0] {
      TRK_IDLE,   // expects lead byte
      TRK_LEAD,   // lead seen, expects second byte
      TRK_SEC,    // expects arm code or pre-disarm code
      TRK_PRE,    // expects lead byte of disarm tail
      TRK_LEAD2,  // expects second byte of disarm tail
      TRK_SEC2    // expects disarm code
   } trk_e;

   localparam int KEY_N      = 5;
   localparam int KEY_LEAD   = 0;
   localparam int KEY_SEC    = 1;
   localparam int KEY_ARM    = 2;
   localparam int KEY_PRE    = 3;
   localparam int KEY_DISARM = 4;
endpackage

// File: rtl/wp_key_match.sv
module wp_key_match #(
   parameter int             AW       = 13,
   parameter int             DW       = 8,
   parameter logic [AW-1:0]  KEY_ADDR = '0,
   parameter logic [DW-1:0]  KEY_DATA = '0
) (
   input  logic          wr_i,
   input  logic [AW-1:0] addr_i,
   input  logic [DW-1:0] data_i,
   output logic          hit_o
);
   assign hit_o = wr_i && (addr_i == KEY_ADDR) && (data_i == KEY_DATA);
endmodule

// File: rtl/wp_load_window.sv
module wp_load_window #(
   parameter int PAGE_BYTES = 64,
   parameter int LOAD_GAP   = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic clear_i,
   input  logic data_wr_i,
   output logic open_o
);
   localparam int CW = $clog2(PAGE_BYTES + 1);
   localparam int GW = $clog2(LOAD_GAP + 2);

   initial begin
      assert (PAGE_BYTES >= 1) else $error("PAGE_BYTES must be at least 1");
      assert (LOAD_GAP >= 0)   else $error("LOAD_GAP must not be negative");
   end

   logic          open_q;
   logic [CW-1:0] cnt_q;
   logic          last_byte;
   logic          gap_expired;

   assign last_byte = (cnt_q == CW'(PAGE_BYTES - 1));

   generate
      if (LOAD_GAP > 0) begin : g_gap_timer
         logic [GW-1:0] gap_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                        gap_q <= '0;
            else if (start_i || data_wr_i || !open_q) gap_q <= '0;
            else                               gap_q <= gap_q + 1'b1;
         end
         assign gap_expired = open_q && !data_wr_i && (gap_q == GW'(LOAD_GAP - 1));
      end else begin : g_no_gap_timer
         assign gap_expired = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open_q <= 1'b0;
         cnt_q  <= '0;
      end else if (clear_i) begin
         open_q <= 1'b0;
         cnt_q  <= '0;
      end else if (start_i) begin
         open_q <= 1'b1;
         cnt_q  <= '0;
      end else if (open_q) begin
         if (data_wr_i) begin
            if (last_byte) open_q <= 1'b0;
            cnt_q <= cnt_q + 1'b1;
         end else if (gap_expired) begin
            open_q <= 1'b0;
         end
      end
   end

   assign open_o = open_q;

   // R4
   page_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (open_q && data_wr_i && last_byte && !start_i) |=> !open_q);

   // R8
   clear_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> !open_q);
endmodule

// File: rtl/wp_seq_guard.sv
module wp_seq_guard #(
   parameter int            AW          = 13,
   parameter int            DW          = 8,
   parameter logic [AW-1:0] ADDR_X      = 13'h1555,
   parameter logic [AW-1:0] ADDR_Y      = 13'h0AAA,
   parameter logic [DW-1:0] CODE_LEAD   = 8'hAA,
   parameter logic [DW-1:0] CODE_SEC    = 8'h55,
   parameter logic [DW-1:0] CODE_ARM    = 8'hA0,
   parameter logic [DW-1:0] CODE_PRE    = 8'h80,
   parameter logic [DW-1:0] CODE_DISARM = 8'h20,
   parameter int            PAGE_BYTES  = 64,
   parameter int            LOAD_GAP    = 8,
   parameter logic          FLAG_INIT   = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pw_cycle_i,
   input  logic          wr_i,
   input  logic [AW-1:0] addr_i,
   input  logic [DW-1:0] data_i,
   output logic          permit_o,
   output logic          cmd_o
);
   import wp_seq_pkg::*;

   initial begin
      assert (AW >= 2 && DW >= 1) else $error("bus widths too small");
      assert (ADDR_X != ADDR_Y)   else $error("command addresses must differ");
   end

   localparam logic [AW-1:0] KEY_A [KEY_N] = '{ADDR_X, ADDR_Y, ADDR_X, ADDR_X, ADDR_X};
   localparam logic [DW-1:0] KEY_D [KEY_N] = '{CODE_LEAD, CODE_SEC, CODE_ARM, CODE_PRE, CODE_DISARM};

   logic             wr_ok;
   logic [KEY_N-1:0] hit;
   trk_e             trk_q, trk_nxt;
   logic             flag_q;
   logic             arm_set, disarm_clr, pass, cmd, data_wr;
   logic             win_open;

   assign wr_ok = wr_i && !pw_cycle_i;

   for (genvar k = 0; k < KEY_N; k++) begin : g_key
      wp_key_match #(
         .AW(AW), .DW(DW), .KEY_ADDR(KEY_A[k]), .KEY_DATA(KEY_D[k])
      ) u_key (
         .wr_i(wr_ok), .addr_i(addr_i), .data_i(data_i), .hit_o(hit[k])
      );
   end

   always_comb begin
      trk_nxt    = trk_q;
      pass       = 1'b0;
      cmd        = 1'b0;
      arm_set    = 1'b0;
      disarm_clr = 1'b0;
      data_wr    = 1'b0;
      if (wr_ok) begin
         if (win_open) begin
            pass    = 1'b1;
            data_wr = 1'b1;
         end else begin
            trk_nxt = TRK_IDLE;
            pass    = !flag_q;
            unique case (trk_q)
               TRK_IDLE:  if (hit[KEY_LEAD]) begin trk_nxt = TRK_LEAD;  cmd = 1'b1; end
               TRK_LEAD:  if (hit[KEY_SEC])  begin trk_nxt = TRK_SEC;   cmd = 1'b1; end
               TRK_SEC: begin
                  if (hit[KEY_ARM]) begin
                     cmd     = 1'b1;
                     arm_set = 1'b1;
                  end else if (hit[KEY_PRE]) begin
                     trk_nxt = TRK_PRE;
                     cmd     = 1'b1;
                  end
               end
               TRK_PRE:   if (hit[KEY_LEAD]) begin trk_nxt = TRK_LEAD2; cmd = 1'b1; end
               TRK_LEAD2: if (hit[KEY_SEC])  begin trk_nxt = TRK_SEC2;  cmd = 1'b1; end
               TRK_SEC2:  if (hit[KEY_DISARM]) begin cmd = 1'b1; disarm_clr = 1'b1; end
               default:   trk_nxt = TRK_IDLE;
            endcase
            if (cmd) pass = 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trk_q  <= TRK_IDLE;
         flag_q <= FLAG_INIT;
      end else if (pw_cycle_i) begin
         trk_q  <= TRK_IDLE;
      end else begin
         trk_q <= trk_nxt;
         if (arm_set)         flag_q <= 1'b1;
         else if (disarm_clr) flag_q <= 1'b0;
      end
   end

   wp_load_window #(.PAGE_BYTES(PAGE_BYTES), .LOAD_GAP(LOAD_GAP)) u_win (
      .clk(clk), .rst_n(rst_n), .start_i(arm_set), .clear_i(pw_cycle_i),
      .data_wr_i(data_wr), .open_o(win_open)
   );

   assign permit_o = pass;
   assign cmd_o    = cmd;

   // R7
   cmd_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(permit_o && cmd_o));

   // R10
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_i |-> (!permit_o && !cmd_o));

   // R8
   pw_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pw_cycle_i |-> (!permit_o && !cmd_o));

   // R8
   flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pw_cycle_i |=> (flag_q == $past(flag_q)));

   // R2
   locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (permit_o && flag_q) |-> win_open);

   // R1
   arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      arm_set |=> (flag_q && win_open));

   // R5
   disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      disarm_clr |=> !flag_q);
endmodule

// File: tb/sim_wp_seq_guard.sv
module sim_wp_seq_guard;
   localparam int PB = 4;
   localparam int LG = 5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pw = 1'b0;
   logic        wr = 1'b0;
   logic [12:0] addr = '0;
   logic [7:0]  data = '0;
   logic        permit, cmd;
   int          n_chk = 0;
   int          n_fail = 0;

   always #2.5 clk = ~clk;

   wp_seq_guard #(.PAGE_BYTES(PB), .LOAD_GAP(LG)) u0 (
      .clk(clk), .rst_n(rst_n), .pw_cycle_i(pw), .wr_i(wr),
      .addr_i(addr), .data_i(data), .permit_o(permit), .cmd_o(cmd)
   );

   // vector: {req[7:0], pw, wr, addr[12:0], data[7:0], exp_permit, exp_cmd}
   localparam int NV = 17;
   localparam logic [32:0] VEC [NV] = '{
      {8'd6, 1'b0, 1'b1, 13'h0100, 8'h12, 1'b1, 1'b0},  // R6 plain write, unprotected
      {8'd1, 1'b0, 1'b1, 13'h1555, 8'hAA, 1'b0, 1'b1},  // R1
      {8'd1, 1'b0, 1'b1, 13'h0AAA, 8'h55, 1'b0, 1'b1},
      {8'd1, 1'b0, 1'b1, 13'h1555, 8'hA0, 1'b0, 1'b1},
      {8'd3, 1'b0, 1'b1, 13'h0040, 8'h11, 1'b1, 1'b0},  // R3 window data
      {8'd3, 1'b0, 1'b1, 13'h1555, 8'hAA, 1'b1, 1'b0},  // R3 code-valued data
      {8'd3, 1'b0, 1'b1, 13'h0042, 8'h13, 1'b1, 1'b0},
      {8'd3, 1'b0, 1'b1, 13'h0043, 8'h14, 1'b1, 1'b0},
      {8'd4, 1'b0, 1'b1, 13'h0044, 8'h15, 1'b0, 1'b0},  // R4 page full
      {8'd10,1'b0, 1'b0, 13'h0000, 8'h00, 1'b0, 1'b0},  // R10
      {8'd5, 1'b0, 1'b1, 13'h1555, 8'hAA, 1'b0, 1'b1},  // R5
      {8'd5, 1'b0, 1'b1, 13'h0AAA, 8'h55, 1'b0, 1'b1},
      {8'd5, 1'b0, 1'b1, 13'h1555, 8'h80, 1'b0, 1'b1},
      {8'd5, 1'b0, 1'b1, 13'h1555, 8'hAA, 1'b0, 1'b1},
      {8'd5, 1'b0, 1'b1, 13'h0AAA, 8'h55, 1'b0, 1'b1},
      {8'd5, 1'b0, 1'b1, 13'h1555, 8'h20, 1'b0, 1'b1},
      {8'd5, 1'b0, 1'b1, 13'h0200, 8'h77, 1'b1, 1'b0}
   };

   task automatic chk(input string req, input logic ep, input logic ec);
      n_chk++;
      if (permit !== ep || cmd !== ec) begin
         n_fail++;
         $display("FAIL %s: permit/cmd = %b/%b, expected %b/%b", req, permit, cmd, ep, ec);
      end
   endtask

   task automatic step(input string req, input logic p, input logic w,
                       input logic [12:0] a, input logic [7:0] d,
                       input logic ep, input logic ec);
      @(negedge clk);
      pw = p; wr = w; addr = a; data = d;
      #1.5;
      chk(req, ep, ec);
   endtask

   task automatic idle(input string req, input int n);
      for (int i = 0; i < n; i++) step(req, 1'b0, 1'b0, 13'h0, 8'h0, 1'b0, 1'b0);
   endtask

   task automatic arm(input string req);
      step(req, 1'b0, 1'b1, 13'h1555, 8'hAA, 1'b0, 1'b1);
      step(req, 1'b0, 1'b1, 13'h0AAA, 8'h55, 1'b0, 1'b1);
      step(req, 1'b0, 1'b1, 13'h1555, 8'hA0, 1'b0, 1'b1);
   endtask

   task automatic finish_run;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      finish_run();
   end

   initial begin
      // R9 reset state
      repeat (3) @(negedge clk);
      #1.5 chk("R9", 1'b0, 1'b0);
      @(negedge clk) rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         step($sformatf("R%0d", VEC[i][32:25]), VEC[i][24], VEC[i][23],
              VEC[i][22:10], VEC[i][9:2], VEC[i][1], VEC[i][0]);
      end

      // R6 mismatch with protection off: passes, tracker back to idle
      step("R6", 1'b0, 1'b1, 13'h1555, 8'hAA, 1'b0, 1'b1);
      step("R6", 1'b0, 1'b1, 13'h0AAA, 8'h33, 1'b1, 1'b0);
      step("R6", 1'b0, 1'b1, 13'h0AAA, 8'h55, 1'b1, 1'b0);

      // R4 idle gap: LG-1 idle keeps window, LG idle closes it
      arm("R1");
      idle("R10", LG - 1);
      step("R4", 1'b0, 1'b1, 13'h0300, 8'h01, 1'b1, 1'b0);
      idle("R10", LG);
      step("R4", 1'b0, 1'b1, 13'h0301, 8'h02, 1'b0, 1'b0);

      // R6 mismatch at third step with protection on: refused
      step("R6", 1'b0, 1'b1, 13'h1555, 8'hAA, 1'b0, 1'b1);
      step("R6", 1'b0, 1'b1, 13'h0AAA, 8'h55, 1'b0, 1'b1);
      step("R6", 1'b0, 1'b1, 13'h1555, 8'h99, 1'b0, 1'b0);
      step("R2", 1'b0, 1'b1, 13'h0400, 8'h44, 1'b0, 1'b0);

      // R8 supply transition drops partial sequence, keeps flag
      step("R8", 1'b0, 1'b1, 13'h1555, 8'hAA, 1'b0, 1'b1);
      step("R8", 1'b1, 1'b1, 13'h0AAA, 8'h55, 1'b0, 1'b0);
      step("R8", 1'b0, 1'b1, 13'h0AAA, 8'h55, 1'b0, 1'b0);
      step("R8", 1'b0, 1'b1, 13'h0500, 8'h45, 1'b0, 1'b0);

      // R8 supply transition closes an open window
      arm("R1");
      step("R8", 1'b1, 1'b0, 13'h0, 8'h0, 1'b0, 1'b0);
      step("R8", 1'b0, 1'b1, 13'h0600, 8'h46, 1'b0, 1'b0);

      // R9 reset reloads unprotected factory state
      @(negedge clk) rst_n = 1'b0; pw = 1'b0; wr = 1'b0;
      #1.5 chk("R9", 1'b0, 1'b0);
      @(negedge clk) rst_n = 1'b1;
      step("R9", 1'b0, 1'b1, 13'h0700, 8'h47, 1'b1, 1'b0);
      idle("R10", 1);

      finish_run();
   end
endmodule